// File: doc/BRIEF.md
# Software-Triggered Reset Sequencer

This block lets software start a chip reset by writing a small control register. Two request bits are offered. One asks for a warm global reset. The other asks for a PLL reset, which is always promoted to a cold reset of the whole chip.

Once a request is accepted, the block drives two active-low reset outputs one after the other. First the global reset is held low for a programmable number of slow always-on clock ticks. Then the power-domain reset is held low for a programmable number of interface clock cycles. When the sequence finishes, the block clears its own register bits according to the class of the reset. A cold reset clears both request bits and reloads the default durations. A warm reset clears only the warm request bit and keeps the programmed durations. A status output reports whether the last completed reset was cold or warm.

The slow domain is modelled as a one-cycle enable pulse, `slow_ce`, that is synchronous to the interface clock. A request crosses into that domain through a two-stage synchronizer that advances only on `slow_ce`.

Top module: `swrst_seq_ctrl`

## Requirements
- R1: The control register sits at offset 0x0. Bit 1 is the warm request and bit 2 is the PLL request. All other bits read 0, and writes to them have no effect.
- R2: The duration register sits at offset 0x4. Bits 7:0 hold the global duration (slow ticks) and bits 12:8 hold the power-domain duration (interface cycles). Bits 31:13 read 0. Any other offset reads 0.
- R3: After `rst_n` is low at a clock edge, the control register is 0, the durations are 6 and 16, both reset outputs are high, and `last_cold` is 1.
- R4: After a request bit is written, `glob_rst_n` goes low at the third `slow_ce` tick that follows the write edge.
- R5: `glob_rst_n` stays low for exactly the programmed number of `slow_ce` ticks.
- R6: `pd_rst_n` goes low at the edge where `glob_rst_n` is released. It stays low for exactly the programmed number of interface clock cycles. The two outputs are never low together.
- R7: A PLL request gives a cold sequence. At its end, both request bits are cleared, the durations return to 6 and 16, and `last_cold` becomes 1.
- R8: A warm-only request gives a warm sequence. At its end, only the warm bit is cleared, the programmed durations are kept, and `last_cold` becomes 0.
- R9: A programmed duration of 0 behaves as 1, so each pulse lasts at least one tick or cycle.
- R10: While a sequence is running, writes to both registers are ignored, and no second sequence follows from them.
- R11: When both request bits are set, the sequence is cold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| slow_ce | input | 1 | One-cycle tick of the slow always-on domain |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| glob_rst_n | output | 1 | Global reset, active low |
| pd_rst_n | output | 1 | Power-domain reset, active low |
| last_cold | output | 1 | 1 when the last completed reset was cold |

## Verification
Register writes become visible on `reg_rdata` from the edge that takes the strobe. A request reaches `glob_rst_n` on the third `slow_ce` tick after that edge. The global phase then ends N ticks later, the power-domain phase ends M interface cycles after that, and the register clearing and `last_cold` update land on that final edge. A behavioural model in the bench steps through these delays on every rising edge. All outputs and the read data are compared 2 ns after each edge, when every register on the path has settled. Directed reads after each scenario confirm which bits survived each reset class.

// File: rtl/swrst_pkg.sv
// Shared types for the software reset sequencer.
// Assumes: 32-bit register data; request bit positions are fixed by the register map.
package swrst_pkg;
    localparam int REG_W   = 32;
    localparam int WARM_BIT = 1;
    localparam int PLL_BIT  = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_GLOB = 2'd1,
        SEQ_PD   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/swrst_regs.sv
// Register file: control (request bits) and duration fields.
// Clears its bits by reset class when the sequencer reports completion.
// Assumes: done is only ever high while busy is high.
module swrst_regs
    import swrst_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int GDUR_W   = 8,
    parameter int PDUR_W   = 5,
    parameter int GDUR_RST = 6,
    parameter int PDUR_RST = 16,
    parameter int CTRL_OFS = 0,
    parameter int TIME_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              done_cold,
    output logic [REG_W-1:0]  rdata,
    output logic              warm_req,
    output logic              pll_req,
    output logic [GDUR_W-1:0] gdur,
    output logic [PDUR_W-1:0] pdur
);
    localparam int PAD_W = REG_W - GDUR_W - PDUR_W;

    logic wr_ctrl, wr_time;
    logic unused_wbits;

    assign wr_ctrl = wr && !busy && (addr == ADDR_W'(CTRL_OFS));
    assign wr_time = wr && !busy && (addr == ADDR_W'(TIME_OFS));
    assign unused_wbits = ^{wdata[REG_W-1:GDUR_W+PDUR_W], wdata[0]};

    // Request bits: warm bit cleared by any completed reset, PLL bit only by cold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_req <= 1'b0;
            pll_req  <= 1'b0;
        end else if (done) begin
            warm_req <= 1'b0;
            if (done_cold) pll_req <= 1'b0;
        end else if (wr_ctrl) begin
            warm_req <= wdata[WARM_BIT];
            pll_req  <= wdata[PLL_BIT];
        end
    end

    // Durations: cold reset reloads defaults, warm leaves them alone.
    always_ff @(posedge clk) begin
        if (!rst_n || (done && done_cold)) begin
            gdur <= GDUR_W'(GDUR_RST);
            pdur <= PDUR_W'(PDUR_RST);
        end else if (wr_time) begin
            gdur <= wdata[GDUR_W-1:0];
            pdur <= wdata[GDUR_W+PDUR_W-1:GDUR_W];
        end
    end

    // Read mux: unmapped offsets and reserved bits return zero.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_OFS)) begin
            rdata[WARM_BIT] = warm_req;
            rdata[PLL_BIT]  = pll_req;
        end else if (addr == ADDR_W'(TIME_OFS)) begin
            rdata = {{PAD_W{1'b0}}, pdur, gdur};
        end
    end

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable({warm_req, pll_req, gdur, pdur}));

    assert_cold_defaults_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_cold) |=> (gdur == GDUR_W'(GDUR_RST) && pdur == PDUR_W'(PDUR_RST)
                                 && !pll_req && !warm_req));

    assert_warm_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_cold) |=> ($stable({pll_req, gdur, pdur}) && !warm_req));
endmodule

// File: rtl/swrst_req_sync.sv
// Multi-stage synchronizer that advances only on the slow-domain enable.
// A synchronous flush empties every stage at once (used while a sequence runs).
// Assumes: ce is a single-cycle pulse synchronous to clk.
module swrst_req_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         flush,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Stage i: takes the input (first stage) or the previous stage on each tick.
            always_ff @(posedge clk) begin
                if (!rst_n || flush) stg[i] <= '0;
                else if (ce)         stg[i] <= (i == 0) ? d : stg[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q == '0));
endmodule

// File: rtl/swrst_pulse_seq.sv
// Reset pulse sequencer: global phase counted in slow ticks, then power-domain
// phase counted in interface cycles. A duration of zero is stretched to one.
// Assumes: req is already synchronized; durations are stable while busy.
module swrst_pulse_seq
    import swrst_pkg::*;
#(
    parameter int GDUR_W = 8,
    parameter int PDUR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_ce,
    input  logic              req,
    input  logic              req_cold,
    input  logic [GDUR_W-1:0] gdur,
    input  logic [PDUR_W-1:0] pdur,
    output logic              glob_rst_n,
    output logic              pd_rst_n,
    output logic              busy,
    output logic              done,
    output logic              done_cold
);
    seq_state_e        state;
    logic [GDUR_W-1:0] gcnt;
    logic [PDUR_W-1:0] pcnt;
    logic              kind_cold;

    // Phase counters and state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            gcnt      <= '0;
            pcnt      <= '0;
            kind_cold <= 1'b0;
        end else begin
            unique case (state)
                SEQ_IDLE: if (slow_ce && req) begin
                    state     <= SEQ_GLOB;
                    gcnt      <= (gdur == '0) ? '0 : gdur - GDUR_W'(1);
                    kind_cold <= req_cold;
                end
                SEQ_GLOB: if (slow_ce) begin
                    if (gcnt == '0) begin
                        state <= SEQ_PD;
                        pcnt  <= (pdur == '0) ? '0 : pdur - PDUR_W'(1);
                    end else begin
                        gcnt <= gcnt - GDUR_W'(1);
                    end
                end
                SEQ_PD: begin
                    if (pcnt == '0) state <= SEQ_IDLE;
                    else            pcnt  <= pcnt - PDUR_W'(1);
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign glob_rst_n = (state != SEQ_GLOB);
    assign pd_rst_n   = (state != SEQ_PD);
    assign busy       = (state != SEQ_IDLE);
    assign done       = (state == SEQ_PD) && (pcnt == '0);
    assign done_cold  = kind_cold;

    assert_glob_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(glob_rst_n) |-> $past(slow_ce));

    assert_pd_follows_glob_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_rst_n) |-> $rose(glob_rst_n));

    assert_pd_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_rst_n && !done) |=> !pd_rst_n);
endmodule

// File: rtl/swrst_seq_ctrl.sv
// Top: software-triggered reset sequencer. Register writes raise a request,
// which is synchronized into the slow domain and run as a global pulse
// followed by a power-domain pulse. Also records whether the last reset was cold.
// Assumes: slow_ce is a one-cycle pulse synchronous to clk; rst_n is a cold reset.
module swrst_seq_ctrl
    import swrst_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int GDUR_W   = 8,
    parameter int PDUR_W   = 5,
    parameter int GDUR_RST = 6,
    parameter int PDUR_RST = 16,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_ce,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              glob_rst_n,
    output logic              pd_rst_n,
    output logic              last_cold
);
    logic              warm_req, pll_req;
    logic [GDUR_W-1:0] gdur;
    logic [PDUR_W-1:0] pdur;
    logic              busy, done, done_cold;
    logic [1:0]        sync_q;

    swrst_regs #(
        .ADDR_W(ADDR_W), .GDUR_W(GDUR_W), .PDUR_W(PDUR_W),
        .GDUR_RST(GDUR_RST), .PDUR_RST(PDUR_RST), .CTRL_OFS(0), .TIME_OFS(4)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .done(done), .done_cold(done_cold), .rdata(reg_rdata),
        .warm_req(warm_req), .pll_req(pll_req), .gdur(gdur), .pdur(pdur)
    );

    swrst_req_sync #(.STAGES(SYNC_N), .W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .ce(slow_ce), .flush(busy),
        .d({pll_req, warm_req | pll_req}), .q(sync_q)
    );

    swrst_pulse_seq #(.GDUR_W(GDUR_W), .PDUR_W(PDUR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce), .req(sync_q[0]),
        .req_cold(sync_q[1]), .gdur(gdur), .pdur(pdur),
        .glob_rst_n(glob_rst_n), .pd_rst_n(pd_rst_n),
        .busy(busy), .done(done), .done_cold(done_cold)
    );

    // Reset-class status: power-on counts as cold; updated when a sequence ends.
    always_ff @(posedge clk) begin
        if (!rst_n)    last_cold <= 1'b1;
        else if (done) last_cold <= done_cold;
    end

    assert_outputs_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_rst_n || pd_rst_n));
endmodule

// File: tb/tb_swrst_seq_ctrl.sv
`timescale 1ns/1ps
module tb_swrst_seq_ctrl;
    localparam int SLOW_DIV = 4;
    localparam int WD_CYC   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_ce = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        glob_rst_n, pd_rst_n, last_cold;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    swrst_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .glob_rst_n(glob_rst_n), .pd_rst_n(pd_rst_n), .last_cold(last_cold)
    );

    // Slow-domain tick every SLOW_DIV interface cycles.
    int div_cnt = 0;
    always @(negedge clk) begin
        div_cnt = (div_cnt + 1) % SLOW_DIV;
        slow_ce <= (div_cnt == 0);
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural reference model, stepped on each rising edge.
    bit m_ok = 0;
    int m_warm, m_pll, m_d1, m_d2, m_cold;
    int m_phase, m_rem, m_kind;
    int q_req[2];
    int q_pll[2];

    always @(posedge clk) begin
        int o_warm, o_pll, o_d1, o_d2;
        if (!rst_n) begin
            m_ok = 1; m_warm = 0; m_pll = 0; m_d1 = 6; m_d2 = 16; m_cold = 1;
            m_phase = 0; m_rem = 0; m_kind = 0;
            q_req = '{0, 0}; q_pll = '{0, 0};
        end else if (m_ok) begin
            o_warm = m_warm; o_pll = m_pll; o_d1 = m_d1; o_d2 = m_d2;
            if (m_phase == 0) begin
                if (reg_wr && reg_addr == 4'h0) begin
                    m_warm = reg_wdata[1]; m_pll = reg_wdata[2];
                end
                if (reg_wr && reg_addr == 4'h4) begin
                    m_d1 = reg_wdata[7:0]; m_d2 = reg_wdata[12:8];
                end
                if (slow_ce) begin
                    if (q_req[1] != 0) begin
                        m_phase = 1;
                        m_rem = (o_d1 == 0) ? 1 : o_d1;
                        m_kind = q_pll[1];
                        q_req = '{0, 0}; q_pll = '{0, 0};
                    end else begin
                        q_req[1] = q_req[0]; q_pll[1] = q_pll[0];
                        q_req[0] = (o_warm | o_pll); q_pll[0] = o_pll;
                    end
                end
            end else if (m_phase == 1) begin
                if (slow_ce) begin
                    m_rem--;
                    if (m_rem == 0) begin
                        m_phase = 2;
                        m_rem = (m_d2 == 0) ? 1 : m_d2;
                    end
                end
            end else begin
                m_rem--;
                if (m_rem == 0) begin
                    m_phase = 0;
                    m_warm = 0;
                    if (m_kind != 0) begin
                        m_pll = 0; m_d1 = 6; m_d2 = 16;
                    end
                    m_cold = m_kind;
                end
            end
        end
    end

    function automatic logic [31:0] exp_rdata(input logic [3:0] a);
        if (a == 4'h0) return 32'(m_pll * 4 + m_warm * 2);
        if (a == 4'h4) return 32'(m_d2 * 256 + m_d1);
        return 32'h0;
    endfunction

    // Per-cycle comparison, 2 ns after the edge.
    always begin
        @(posedge clk);
        #2;
        if (m_ok) begin
            chk("R4 R5 R9 glob_rst_n", 32'(glob_rst_n), 32'(m_phase != 1));
            chk("R6 R9 pd_rst_n", 32'(pd_rst_n), 32'(m_phase != 2));
            chk("R7 R8 last_cold", 32'(last_cold), 32'(m_cold));
            chk("R1 R2 rdata", reg_rdata, exp_rdata(reg_addr));
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 4'h0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(WD_CYC);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        @(negedge clk); rst_n = 1'b1;
        // R3: reset state
        rd_chk("R3 ctrl reset", 4'h0, 32'h0);
        rd_chk("R3 time reset", 4'h4, 32'h0000_1006);
        chk("R3 last_cold reset", 32'(last_cold), 32'h1);
        chk("R3 outputs high", 32'({glob_rst_n, pd_rst_n}), 32'h3);
        // R1: reserved control bits
        wr_reg(4'h0, 32'hFFFF_FFF9);
        rd_chk("R1 reserved bits", 4'h0, 32'h0);
        idle(30);
        chk("R1 no sequence", 32'(glob_rst_n), 32'h1);
        // R2: duration field layout and unmapped offset
        wr_reg(4'h4, 32'hFFFF_FFFF);
        rd_chk("R2 time mask", 4'h4, 32'h0000_1FFF);
        rd_chk("R2 unmapped", 4'h8, 32'h0);
        // R8: warm sequence keeps durations
        wr_reg(4'h4, 32'h0000_0305);
        wr_reg(4'h0, 32'h0000_0002);
        idle(100);
        rd_chk("R8 warm bit cleared", 4'h0, 32'h0);
        rd_chk("R8 durations kept", 4'h4, 32'h0000_0305);
        chk("R8 last_cold warm", 32'(last_cold), 32'h0);
        // R9: zero durations stretched to one
        wr_reg(4'h4, 32'h0);
        wr_reg(4'h0, 32'h2);
        idle(60);
        rd_chk("R9 durations zero kept", 4'h4, 32'h0);
        // R10: writes during a sequence ignored
        wr_reg(4'h4, 32'h0000_0A14);
        wr_reg(4'h0, 32'h2);
        idle(20);
        chk("R10 in global phase", 32'(glob_rst_n), 32'h0);
        wr_reg(4'h0, 32'h4);
        wr_reg(4'h4, 32'h0000_1F01);
        idle(150);
        rd_chk("R10 ctrl write ignored", 4'h0, 32'h0);
        rd_chk("R10 time write ignored", 4'h4, 32'h0000_0A14);
        chk("R10 stays warm", 32'(last_cold), 32'h0);
        // R7: PLL request becomes cold
        wr_reg(4'h4, 32'h0000_0203);
        wr_reg(4'h0, 32'h4);
        idle(80);
        rd_chk("R7 ctrl cleared", 4'h0, 32'h0);
        rd_chk("R7 defaults restored", 4'h4, 32'h0000_1006);
        chk("R7 last_cold", 32'(last_cold), 32'h1);
        // R11: both bits set is cold
        wr_reg(4'h4, 32'h0);
        wr_reg(4'h0, 32'h2);
        idle(60);
        chk("R11 warm first", 32'(last_cold), 32'h0);
        wr_reg(4'h4, 32'h0000_0102);
        wr_reg(4'h0, 32'h6);
        idle(80);
        rd_chk("R11 ctrl cleared", 4'h0, 32'h0);
        rd_chk("R11 defaults", 4'h4, 32'h0000_1006);
        chk("R11 cold", 32'(last_cold), 32'h1);
        // R5 R6: longest durations
        wr_reg(4'h4, 32'h0000_1FFF);
        wr_reg(4'h0, 32'h2);
        idle(1200);
        rd_chk("R5 long warm done", 4'h0, 32'h0);
        // R3: cold reset in the middle of a sequence
        wr_reg(4'h4, 32'h0000_0A20);
        wr_reg(4'h0, 32'h2);
        idle(40);
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        rd_chk("R3 ctrl after reset", 4'h0, 32'h0);
        rd_chk("R3 time after reset", 4'h4, 32'h0000_1006);
        chk("R3 outputs after reset", 32'({glob_rst_n, pd_rst_n, last_cold}), 32'h7);
        idle(20);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule